// File: doc/BRIEF.md
# Write-Update Coherent Cache Controller

This block is the private cache controller of one processor in a small bus-based multiprocessor. It keeps a direct-mapped array of one-word lines. Each filled line holds a tag, a data word and one of three coherence states: exclusive-clean, shared-clean or modified. Coherence follows a write-update scheme. A write to a line that other caches may also hold is sent on the bus as a word update. Memory and every other holder take the new value, so no copy is ever invalidated. A wired-OR sharing signal, driven by the other caches, tells the requester whether anyone else still holds the word.

The controller has three ports. The processor port takes one read or write at a time and returns a one-cycle `cpu_done` strobe. The bus master port issues three commands: word reads, word updates and victim write-backs. A transfer completes in the cycle its grant is high. In that same cycle the sharing input and the read data are sampled. The snoop port watches transfers made by other masters. It raises its sharing output combinationally when it holds the address. It supplies modified data on a snooped read and overwrites its local copy on a snooped update. Arbitration, memory and the other caches are outside the block.

Top module: `wu_cache`

## Requirements
- R1: After reset every line is empty, so the first access to any address misses and issues a bus read (command 0) for that address.
- R2: A read that hits returns the stored word with `cpu_done` in the same cycle, with no bus request.
- R3: On a miss, the fill read (command 0) installs the word from `bus_rdata` as shared-clean if `bus_shared` is high in the grant cycle, and as exclusive-clean otherwise.
- R4: A write hit on an exclusive-clean or modified line completes with no bus transfer and leaves the line modified. A later write to it also stays off the bus.
- R5: A write hit on a shared-clean line issues one update (command 1) carrying the address and the new word, and completes in its grant cycle. The line stays shared-clean if `bus_shared` was high in that cycle and becomes exclusive-clean otherwise. The request stays stable on the bus until it is granted.
- R6: `snp_hit` is high in the cycle `snp_valid` presents an address the cache holds, and low for any address it does not hold.
- R7: A snooped update (command 1) that hits replaces the local word, and a later processor read returns the new value.
- R8: A snooped read (command 0) that hits a modified line raises `snp_supply` with the line's word on `snp_data`. A snooped read that hits any line leaves it shared-clean, so the next processor write to it is broadcast.
- R9: A miss whose victim line is modified first issues a write-back (command 2) of the victim's address and word, then the fill read. A clean victim is dropped with no write-back.
- R10: While `snp_valid` is high, no processor request completes from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read word, valid with done |
| bus_req | output | 1 | Bus transfer wanted |
| bus_cmd | output | 2 | 0 read, 1 update, 2 write-back |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Word for update or write-back |
| bus_gnt | input | 1 | Transfer happens this cycle |
| bus_rdata | input | DW | Read data in the grant cycle |
| bus_shared | input | 1 | Wired-OR sharing signal from other caches |
| snp_valid | input | 1 | Another master's transfer is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_wdata | input | DW | Snooped update word |
| snp_hit | output | 1 | This cache holds the snooped address |
| snp_supply | output | 1 | This cache supplies the word (modified hit on read) |
| snp_data | output | DW | Supplied word |

## Verification
Processor reads and writes are mixed with snooped reads and updates over an address range eight times the array size, so that hits, clean evictions and modified evictions all occur. The sharing input is forced low, forced high, or drawn at random per grant. Forcing it apart separates the exclusive install and downgrade paths from the shared ones. These paths can only be told apart by whether the next write reaches the bus. Random grant delays show whether each request stays stable until granted. Snoops are interleaved with processor traffic, and one is held during a pending hit, to show the update-in-place, supply and stall behaviour.

// File: rtl/wu_cache.sv
module wu_cache #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          snp_hit,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam logic [1:0] C_RD = 2'd0, C_UPD = 2'd1, C_WB = 2'd2;

  typedef enum logic [1:0] {L_EXCL, L_SHRD, L_MOD} lstate_t;
  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_UPD} fsm_t;

  fsm_t           st;
  logic [LINES-1:0] vld;
  logic [TW-1:0]  tags [LINES];
  logic [DW-1:0]  dats [LINES];
  lstate_t        lst  [LINES];

  wire [IW-1:0] c_idx = cpu_addr[IW-1:0];
  wire [TW-1:0] c_tag = cpu_addr[AW-1:IW];
  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire [TW-1:0] s_tag = snp_addr[AW-1:IW];

  wire c_hit = vld[c_idx] && tags[c_idx] == c_tag;
  wire s_own = vld[s_idx] && tags[s_idx] == s_tag;
  wire c_shrd = lst[c_idx] == L_SHRD;

  assign snp_hit    = snp_valid && s_own;
  assign snp_supply = snp_hit && snp_cmd == C_RD && lst[s_idx] == L_MOD;
  assign snp_data   = dats[s_idx];

  assign cpu_rdata = dats[c_idx];
  assign cpu_done  = (st == S_IDLE && cpu_req && !snp_valid && c_hit && !(cpu_we && c_shrd))
                  || (st == S_UPD && bus_gnt);

  assign bus_req   = st != S_IDLE;
  assign bus_cmd   = st == S_WB ? C_WB : st == S_UPD ? C_UPD : C_RD;
  assign bus_addr  = st == S_WB ? {tags[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = st == S_WB ? dats[c_idx] : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      vld <= '0;
    end else begin
      if (snp_hit) begin
        if (snp_cmd == C_RD) lst[s_idx] <= L_SHRD;
        if (snp_cmd == C_UPD) begin
          dats[s_idx] <= snp_wdata;
          lst[s_idx]  <= L_SHRD;
        end
      end
      case (st)
        S_IDLE: if (cpu_req && !snp_valid) begin
          if (c_hit) begin
            if (cpu_we) begin
              if (c_shrd) st <= S_UPD;
              else begin
                dats[c_idx] <= cpu_wdata;
                lst[c_idx]  <= L_MOD;
              end
            end
          end else begin
            st <= (vld[c_idx] && lst[c_idx] == L_MOD) ? S_WB : S_FILL;
          end
        end
        S_WB: if (bus_gnt) st <= S_FILL;
        S_FILL: if (bus_gnt) begin
          vld[c_idx]  <= 1'b1;
          tags[c_idx] <= c_tag;
          dats[c_idx] <= bus_rdata;
          lst[c_idx]  <= bus_shared ? L_SHRD : L_EXCL;
          st <= S_IDLE;
        end
        S_UPD: if (bus_gnt) begin
          dats[c_idx] <= cpu_wdata;
          lst[c_idx]  <= bus_shared ? L_SHRD : L_EXCL;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_writeback_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == C_WB |=> bus_req && bus_cmd == C_RD);

  a_r3_fill_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == C_RD |=> !bus_req);

  a_r5_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_cmd));

  a_r6_supply_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_hit);

  a_r8_supply_once: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> !(snp_valid && snp_addr == $past(snp_addr) && snp_supply));

  a_r10_snoop_stalls_idle: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !bus_req |-> !cpu_done);
endmodule

// File: tb/tb_wu_cache.sv
`timescale 1ns/1ps
module tb_wu_cache;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [11:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_done;
  logic [31:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [11:0] snp_addr = 0;
  logic [31:0] snp_wdata = 0;
  logic snp_hit, snp_supply;
  logic [31:0] snp_data;

  logic [31:0] mem [64];
  assign bus_rdata = mem[bus_addr[5:0]];

  wu_cache dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int force_sh = 0;
  bit rv [8];
  int rt [8];
  int rs [8];
  logic [31:0] rd [8];

  int ntr;
  logic [1:0] tcmd [4];
  logic [11:0] taddr [4];
  logic [31:0] twd [4], trd [4];
  bit tsh [4];

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit ref_hit(int a);
    return rv[a % 8] && rt[a % 8] == a / 8;
  endfunction

  task automatic op(bit we, int a, logic [31:0] wd);
    bit got = 0;
    logic [31:0] rdv = 0;
    int ix = a % 8, k = 0;
    cpu_we = we; cpu_addr = 12'(a); cpu_wdata = wd; cpu_req = 1; ntr = 0;
    for (int cyc = 0; cyc < 60 && !got; cyc++) begin
      @(negedge clk);
      bus_gnt = bus_req && ($urandom % 2 == 0);
      if (bus_gnt) bus_shared = (force_sh < 0) ? 1'($urandom % 2) : 1'(force_sh);
      #1;
      if (bus_gnt && ntr < 4) begin
        tcmd[ntr] = bus_cmd; taddr[ntr] = bus_addr; twd[ntr] = bus_wdata;
        trd[ntr] = bus_rdata; tsh[ntr] = bus_shared; ntr++;
        if (bus_cmd != 0) mem[bus_addr[5:0]] = bus_wdata;
      end
      if (cpu_done) begin got = 1; rdv = cpu_rdata; end
      @(posedge clk); #1;
      bus_gnt = 0; bus_shared = 0;
    end
    cpu_req = 0;
    chk(got, "R2 done", 32'(got), 1);
    if (!ref_hit(a)) begin
      if (rv[ix] && rs[ix] == 2) begin
        chk(ntr > k && tcmd[k] == 2 && taddr[k] == 12'(rt[ix] * 8 + ix) && twd[k] == rd[ix],
            "R9 writeback", {20'(tcmd[k]), taddr[k]}, 32'(rt[ix] * 8 + ix) | 32'h2000);
        k++;
      end
      chk(ntr > k && tcmd[k] == 0 && taddr[k] == 12'(a), "R3 fill", {20'(tcmd[k]), taddr[k]}, 32'(a));
      rv[ix] = 1; rt[ix] = a / 8; rd[ix] = trd[k]; rs[ix] = tsh[k] ? 1 : 0; k++;
    end
    if (we) begin
      if (rs[ix] == 1) begin
        chk(ntr > k && tcmd[k] == 1 && taddr[k] == 12'(a) && twd[k] == wd,
            "R5 update", twd[k], wd);
        rs[ix] = tsh[k] ? 1 : 0; k++;
      end else rs[ix] = 2;
      rd[ix] = wd;
    end else begin
      chk(rdv == rd[ix], "R2 read data", rdv, rd[ix]);
    end
    chk(ntr == k, "R4 bus count", 32'(ntr), 32'(k));
  endtask

  task automatic snoop(logic [1:0] c, int a, logic [31:0] wd);
    int ix = a % 8;
    bit h = ref_hit(a);
    bit sup = h && rs[ix] == 2 && c == 0;
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = 12'(a); snp_wdata = wd;
    #1;
    chk(snp_hit == h, "R6 snoop hit", 32'(snp_hit), 32'(h));
    chk(snp_supply == sup, "R8 supply", 32'(snp_supply), 32'(sup));
    if (sup) begin
      chk(snp_data == rd[ix], "R8 supply data", snp_data, rd[ix]);
      mem[a] = snp_data;
    end
    @(posedge clk); #1;
    snp_valid = 0;
    if (h) begin
      rs[ix] = 1;
      if (c == 1) rd[ix] = wd;
    end
    if (c == 1) mem[a] = wd;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 8; i++) begin rv[i] = 0; rt[i] = 0; rs[i] = 0; rd[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk(!bus_req && !cpu_done, "R1 reset idle", {31'b0, bus_req}, 0);

    force_sh = 0;
    op(0, 5, 0);
    chk(ntr == 1 && tcmd[0] == 0, "R1 first access misses", 32'(ntr), 1);
    op(1, 5, 32'h1111_1111);
    chk(ntr == 0, "R4 exclusive write local", 32'(ntr), 0);
    snoop(0, 5, 0);
    force_sh = 1;
    op(1, 5, 32'h2222_2222);
    op(1, 5, 32'h3333_3333);
    chk(ntr == 1 && tcmd[0] == 1, "R5 stays shared", 32'(ntr), 1);
    force_sh = 0;
    op(1, 5, 32'h4444_4444);
    op(1, 5, 32'h5555_5555);
    chk(ntr == 0, "R5 downgraded to exclusive", 32'(ntr), 0);
    op(0, 13, 0);
    chk(ntr == 2 && tcmd[0] == 2, "R9 dirty victim", 32'(ntr), 2);
    op(0, 21, 0);
    chk(ntr == 1, "R9 clean victim dropped", 32'(ntr), 1);
    snoop(1, 21, 32'h7777_0021);
    op(0, 21, 0);
    chk(ntr == 0 && rd[5] == 32'h7777_0021, "R7 update in place", rd[5], 32'h7777_0021);
    snoop(0, 40, 0);

    @(negedge clk);
    cpu_we = 0; cpu_addr = 21; cpu_req = 1;
    snp_valid = 1; snp_cmd = 0; snp_addr = 12'd41;
    #1;
    chk(!cpu_done, "R10 stall", {31'b0, cpu_done}, 0);
    @(posedge clk); @(negedge clk); #1;
    chk(!cpu_done, "R10 stall second cycle", {31'b0, cpu_done}, 0);
    snp_valid = 0; #1;
    chk(cpu_done && cpu_rdata == 32'h7777_0021, "R10 resume", cpu_rdata, 32'h7777_0021);
    @(posedge clk); #1 cpu_req = 0;

    force_sh = -1;
    for (int n = 0; n < 400; n++) begin
      int a = $urandom % 64;
      int p = $urandom % 4;
      logic [31:0] w = $urandom;
      if (p == 0) op(0, a, 0);
      else if (p == 1) op(1, a, w);
      else begin
        logic [1:0] c = 1'($urandom % 2);
        if (ref_hit(a) && rs[a % 8] != 1) c = 0;
        snoop(c, a, w);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule